// File: doc/BRIEF.md
# Content-Addressable Memory Host Port Sequencer

This block sits between a 16-bit host bus and the registers of a content-addressable memory device. In each clock cycle it decodes three active-low controls (enable, command/data select, write) into an idle, command or data cycle of either direction. It then picks the register or array port that the cycle reaches, raises a one-hot load strobe for writes, steers the read multiplexer for reads, and turns the bus driver on only for reads that the device is allowed to answer.

Where a cycle lands depends on context. Command writes normally feed the instruction decoder, but an instruction carrying the address flag sends the next command write to the address register. A transfer-one-cycle instruction sends exactly one following command cycle to a named register. Command reads alternate between the low and high halves of the 32-bit status word. Data cycles go to a persistent source and a persistent destination, which are chosen by instructions. A paged device-select compare decides whether the device answers at all. An all-ones device-select value lets the device accept writes but never drive reads.

The match array, the priority logic and instruction execution are outside the block. Status, next-free address and array read data arrive as inputs, and array accesses leave as strobes plus a mode code. The small registers that the sequencer itself depends on are modelled inside a register bank.

Top module: `cam_host_seq`

## Requirements
- R1: `en_n`=1 is idle. With `en_n`=0, `cmd_n`=0 gives a command cycle and `cmd_n`=1 a data cycle, while `wr_n`=0 writes and `wr_n`=1 reads. `bus_oe` is 1 only on an accepted read, and `bus_out` is 0 whenever `bus_oe` is 0.
- R2: An accepted command write with no pending redirection and no address flag loads the instruction decoder (strobe bit 1).
- R3: After the decoder accepts an instruction whose opcode (bits 15:12) is not 1, 2 or 3 and whose bit 11 is set, the next accepted command write loads the address register (bit 2). Idle and rejected cycles keep the flag, and any other accepted cycle clears it.
- R4: An instruction with opcode 1 and bits 3:0 below 8 is a one-cycle transfer. The next accepted command cycle, in either direction, reaches the register named by code 0 address, 1 control (bit 3), 2 page (bit 4), 3 segment (bit 5) or 4 device select (bit 6). An accepted data cycle cancels the transfer, and idle cycles keep it.
- R5: Code 5 names the next-free address. A command read then returns `nfa_in`. A command write is dropped with no strobe, but it still uses up the transfer.
- R6: A command read that has no redirection returns status bits 15:0 (`rd_sel` 8). A command read directly after such a read returns bits 31:16 (`rd_sel` 9). Any other cycle in between, idle cycles included, restarts the sequence at bits 15:0.
- R7: Data writes go to the destination and data reads come from the source. Both are the comparand after reset. Opcode 2 sets the source and opcode 3 the destination, using code bits 2:0: 0 comparand (12), 1 mask 1 (13), 2 mask 2 (14), 3 array at address, 4 array at next free (destination only), 5 array at top match. The array cases all use bit 15 and drive `arr_mode` 0, 1 or 2. Invalid codes are ignored.
- R8: A transfer with code 6 followed by a command read returns {`DEV_ID`, bits 11:0 of the last accepted source-selecting instruction}. Code 7 returns {4'h0, bits 11:0 of the last destination-selecting instruction}. A command write after code 6 or 7 is dropped.
- R9: When device select differs from page and is not FFFFh, reads are not driven and writes load nothing.
- R10: When device select is FFFFh and differs from page, writes are accepted and reads are not driven.
- R11: While deselected, a one-cycle transfer to device select (16'h1004) is still accepted, and so is the device-select write that follows it.
- R12: `ld_strobe` has at most one bit set, and the bit index equals the target code that is also used for `rd_sel`.
- R13: Reset sets page and device select to 0 so that the device is selected. It clears the pending transfer, the address flag and the status phase, and makes the comparand both source and destination.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| en_n | input | 1 | Cycle enable, active low |
| cmd_n | input | 1 | Low for command cycle, high for data cycle |
| wr_n | input | 1 | Low for write, high for read |
| bus_in | input | 16 | Host write data |
| status_in | input | 32 | Device status word |
| nfa_in | input | 16 | Next-free address value |
| arr_rd_data | input | 16 | Array read data |
| bus_out | output | 16 | Host read data, zero when not driven |
| bus_oe | output | 1 | Bus driver enable |
| ld_strobe | output | 16 | One-hot register load strobe, indexed by target code |
| rd_sel | output | 4 | Read multiplexer select (target code, 0 when none) |
| arr_we | output | 1 | Array write strobe |
| arr_re | output | 1 | Array read strobe |
| arr_mode | output | 2 | Array addressing: 0 address, 1 next free, 2 top match |

## Verification
Two functions can act on the same cycle: the device-select gate and the one-cycle redirection. A transfer can be pending while the device is deselected, and then the gate alone decides whether that transfer is used up. The directed part of the bench moves the page away from device select, then issues the device-select transfer and the write that follows it while deselected. A bench model predicts every strobe, bus enable and read value each cycle. The random part mixes transfers, selections and page/device-select writes so that gating, redirection and the status phase overlap freely.

// File: rtl/cam_host_pkg.sv
// Package: shared target codes and decode helpers for the host port sequencer.
// Assumes a 16-bit instruction word with opcode in bits 15:12.
package cam_host_pkg;

    typedef enum logic [3:0] {
        T_NONE  = 4'd0,
        T_INSTR = 4'd1,
        T_ADDR  = 4'd2,
        T_CTRL  = 4'd3,
        T_PAGE  = 4'd4,
        T_SEG   = 4'd5,
        T_DSEL  = 4'd6,
        T_NFA   = 4'd7,
        T_STLO  = 4'd8,
        T_STHI  = 4'd9,
        T_PSRD  = 4'd10,
        T_PDRD  = 4'd11,
        T_CMP   = 4'd12,
        T_MSK1  = 4'd13,
        T_MSK2  = 4'd14,
        T_ARR   = 4'd15
    } tgt_e;

    localparam logic [3:0] OPC_XFER = 4'd1;
    localparam logic [3:0] OPC_SRC  = 4'd2;
    localparam logic [3:0] OPC_DST  = 4'd3;
    localparam int         NTGT     = 16;

    // Map a one-cycle transfer code to its target for the given direction.
    function automatic tgt_e xfer_target(input logic [2:0] code, input logic wr);
        case (code)
            3'd0:    return T_ADDR;
            3'd1:    return T_CTRL;
            3'd2:    return T_PAGE;
            3'd3:    return T_SEG;
            3'd4:    return T_DSEL;
            3'd5:    return wr ? T_NONE : T_NFA;
            3'd6:    return wr ? T_NONE : T_PSRD;
            default: return wr ? T_NONE : T_PDRD;
        endcase
    endfunction

    // Map a persistent selection code to its data-cycle target.
    function automatic tgt_e pers_target(input logic [2:0] code);
        case (code)
            3'd0:    return T_CMP;
            3'd1:    return T_MSK1;
            3'd2:    return T_MSK2;
            default: return T_ARR;
        endcase
    endfunction

    // Array addressing mode of a persistent selection code.
    function automatic logic [1:0] arr_mode_of(input logic [2:0] code);
        case (code)
            3'd4:    return 2'd1;
            3'd5:    return 2'd2;
            default: return 2'd0;
        endcase
    endfunction

    // True for targets held as plain registers inside the bank.
    function automatic logic is_stored(input int k);
        return (k >= 2 && k <= 6) || (k >= 12 && k <= 14);
    endfunction

endpackage

// File: rtl/cam_sel_gate.sv
// Module: device-select gate. Compares device select with page address and
// flags the broadcast (all ones) value. Purely combinational.
module cam_sel_gate #(
    parameter int DW = 16
) (
    input  logic [DW-1:0] page_q,
    input  logic [DW-1:0] dsel_q,
    output logic          dev_match,
    output logic          dev_bcast
);
    localparam logic [DW-1:0] ALL_ONES = '1;

    // Compare the two selection registers.
    always_comb begin
        dev_match = (page_q == dsel_q);
        dev_bcast = (dsel_q == ALL_ONES);
    end
endmodule

// File: rtl/cam_cycle_decode.sv
// Module: cycle decoder. Classifies each bus cycle, chooses its target from
// context (one-cycle transfer, address flag, status phase, persistent
// selections), applies the device-select gate and keeps the sequencing state.
// Assumes opcode in bits 15:12, selection codes in bits 2:0.
module cam_cycle_decode import cam_host_pkg::*; #(
    parameter int DW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          en_n,
    input  logic          cmd_n,
    input  logic          wr_n,
    input  logic [DW-1:0] bus_in,
    input  logic          dev_match,
    input  logic          dev_bcast,
    output tgt_e          tgt,
    output logic          acc,
    output logic          is_wr,
    output logic [2:0]    ps_code,
    output logic [2:0]    pd_code,
    output logic [11:0]   ps_instr,
    output logic [11:0]   pd_instr
);
    logic       active, is_cmd;
    logic [3:0] opc;
    logic       xfer_pend, addr_flag, st_hi;
    logic [2:0] xfer_code;
    logic       instr_ld, dsel_xfer_instr, gate_ok;
    logic       src_ok, dst_ok;

    // Basic cycle classification from the active-low controls.
    always_comb begin
        active = ~en_n;
        is_cmd = ~cmd_n;
        is_wr  = ~wr_n;
        opc    = bus_in[15:12];
    end

    // Target selection by cycle type and sequencing context.
    always_comb begin
        if (!active)
            tgt = T_NONE;
        else if (is_cmd) begin
            if (xfer_pend)
                tgt = xfer_target(xfer_code, is_wr);
            else if (is_wr)
                tgt = addr_flag ? T_ADDR : T_INSTR;
            else
                tgt = st_hi ? T_STHI : T_STLO;
        end else
            tgt = is_wr ? pers_target(pd_code) : pers_target(ps_code);
    end

    // Device-select gating, with the device-select path always open.
    always_comb begin
        dsel_xfer_instr = (tgt == T_INSTR) && (opc == OPC_XFER) && (bus_in[3:0] == 4'd4);
        if (is_wr)
            gate_ok = dev_match || dev_bcast || (tgt == T_DSEL) || dsel_xfer_instr;
        else
            gate_ok = dev_match;
        acc      = active && gate_ok;
        instr_ld = acc && is_wr && (tgt == T_INSTR);
        src_ok   = (bus_in[2:0] <= 3'd5) && (bus_in[2:0] != 3'd4);
        dst_ok   = (bus_in[2:0] <= 3'd5);
    end

    // Sequencing state: transfer, address flag, status phase, selections.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            xfer_pend <= 1'b0;
            xfer_code <= 3'd0;
            addr_flag <= 1'b0;
            st_hi     <= 1'b0;
            ps_code   <= 3'd0;
            pd_code   <= 3'd0;
            ps_instr  <= 12'd0;
            pd_instr  <= 12'd0;
        end else begin
            st_hi <= acc && is_cmd && !is_wr && (tgt == T_STLO);
            if (acc) begin
                xfer_pend <= instr_ld && (opc == OPC_XFER) && !bus_in[3];
                xfer_code <= bus_in[2:0];
                addr_flag <= instr_ld && (opc != OPC_XFER) && (opc != OPC_SRC)
                             && (opc != OPC_DST) && bus_in[11];
            end
            if (instr_ld && (opc == OPC_SRC) && src_ok) begin
                ps_code  <= bus_in[2:0];
                ps_instr <= bus_in[11:0];
            end
            if (instr_ld && (opc == OPC_DST) && dst_ok) begin
                pd_code  <= bus_in[2:0];
                pd_instr <= bus_in[11:0];
            end
        end
    end

    // R4: a pending transfer is used up by the command cycle that takes it.
    a_r4_one_shot: assert property (@(posedge clk) disable iff (!rst_n)
        (acc && is_cmd && xfer_pend) |=> !xfer_pend);

    // R4: an accepted data cycle cancels a pending transfer.
    a_r4_data_cancels: assert property (@(posedge clk) disable iff (!rst_n)
        (acc && !is_cmd) |=> !xfer_pend);

    // R7: the source never selects array-at-next-free.
    a_r7_src_code_valid: assert property (@(posedge clk) disable iff (!rst_n)
        ps_code != 3'd4);
endmodule

// File: rtl/cam_reg_bank.sv
// Module: stub register bank. Holds the small host-visible registers, loads
// them from one-hot strobes and multiplexes read data by target code.
// Assumes DW >= 16 and a 2*DW status word.
module cam_reg_bank import cam_host_pkg::*; #(
    parameter int          DW     = 16,
    parameter logic [3:0]  DEV_ID = 4'h5
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [NTGT-1:0] ld,
    input  tgt_e            rd_sel,
    input  logic [DW-1:0]   bus_in,
    input  logic [2*DW-1:0] status_in,
    input  logic [DW-1:0]   nfa_in,
    input  logic [DW-1:0]   arr_rd_data,
    input  logic [11:0]     ps_instr,
    input  logic [11:0]     pd_instr,
    output logic [DW-1:0]   rdata,
    output logic [DW-1:0]   page_q,
    output logic [DW-1:0]   dsel_q
);
    localparam int PADW = DW - 16;

    logic [DW-1:0] rf [NTGT];

    // One register per stored target; the rest tie to zero.
    for (genvar k = 0; k < NTGT; k++) begin : g_rf
        if (is_stored(k)) begin : g_reg
            // Load the register on its strobe.
            always_ff @(posedge clk) begin
                if (!rst_n)
                    rf[k] <= '0;
                else if (ld[k])
                    rf[k] <= bus_in;
            end
        end else begin : g_tie
            assign rf[k] = '0;
        end
    end

    assign page_q = rf[T_PAGE];
    assign dsel_q = rf[T_DSEL];

    // Read multiplexer by target code.
    always_comb begin
        case (rd_sel)
            T_ADDR, T_CTRL, T_PAGE, T_SEG, T_DSEL,
            T_CMP, T_MSK1, T_MSK2: rdata = rf[rd_sel];
            T_NFA:  rdata = nfa_in;
            T_STLO: rdata = status_in[DW-1:0];
            T_STHI: rdata = status_in[2*DW-1:DW];
            T_PSRD: rdata = {{PADW{1'b0}}, DEV_ID, ps_instr};
            T_PDRD: rdata = {{PADW{1'b0}}, 4'h0, pd_instr};
            T_ARR:  rdata = arr_rd_data;
            default: rdata = '0;
        endcase
    end

    // R5: the next-free address is never loaded.
    a_r5_nfa_readonly: assert property (@(posedge clk) disable iff (!rst_n)
        !ld[T_NFA]);
endmodule

// File: rtl/cam_host_seq.sv
// Module: top of the host port sequencer. Wires decoder, gate and register
// bank, and forms load strobes, read select, bus enable and array strobes.
// Assumes a 16-bit bus; the bus driver itself lives outside.
module cam_host_seq import cam_host_pkg::*; #(
    parameter int         DW     = 16,
    parameter logic [3:0] DEV_ID = 4'h5
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            en_n,
    input  logic            cmd_n,
    input  logic            wr_n,
    input  logic [DW-1:0]   bus_in,
    input  logic [2*DW-1:0] status_in,
    input  logic [DW-1:0]   nfa_in,
    input  logic [DW-1:0]   arr_rd_data,
    output logic [DW-1:0]   bus_out,
    output logic            bus_oe,
    output logic [15:0]     ld_strobe,
    output logic [3:0]      rd_sel,
    output logic            arr_we,
    output logic            arr_re,
    output logic [1:0]      arr_mode
);
    tgt_e          tgt, rsel;
    logic          acc, is_wr, dev_match, dev_bcast;
    logic [2:0]    ps_code, pd_code;
    logic [11:0]   ps_instr, pd_instr;
    logic [DW-1:0] rdata, page_q, dsel_q;

    cam_sel_gate #(.DW(DW)) u_gate (
        .page_q(page_q), .dsel_q(dsel_q),
        .dev_match(dev_match), .dev_bcast(dev_bcast)
    );

    cam_cycle_decode #(.DW(DW)) u_dec (
        .clk(clk), .rst_n(rst_n), .en_n(en_n), .cmd_n(cmd_n), .wr_n(wr_n),
        .bus_in(bus_in), .dev_match(dev_match), .dev_bcast(dev_bcast),
        .tgt(tgt), .acc(acc), .is_wr(is_wr),
        .ps_code(ps_code), .pd_code(pd_code),
        .ps_instr(ps_instr), .pd_instr(pd_instr)
    );

    cam_reg_bank #(.DW(DW), .DEV_ID(DEV_ID)) u_bank (
        .clk(clk), .rst_n(rst_n), .ld(ld_strobe), .rd_sel(rsel),
        .bus_in(bus_in), .status_in(status_in), .nfa_in(nfa_in),
        .arr_rd_data(arr_rd_data), .ps_instr(ps_instr), .pd_instr(pd_instr),
        .rdata(rdata), .page_q(page_q), .dsel_q(dsel_q)
    );

    // Form strobes, read select and bus direction from the accepted cycle.
    always_comb begin
        ld_strobe = '0;
        if (acc && is_wr && (tgt != T_NONE))
            ld_strobe[tgt] = 1'b1;
        rsel     = (acc && !is_wr) ? tgt : T_NONE;
        rd_sel   = rsel;
        bus_oe   = acc && !is_wr;
        bus_out  = bus_oe ? rdata : '0;
        arr_we   = ld_strobe[T_ARR];
        arr_re   = (rsel == T_ARR);
        arr_mode = is_wr ? arr_mode_of(pd_code) : arr_mode_of(ps_code);
    end

    // R1: the bus is driven only during an enabled read cycle.
    a_r1_oe_read_only: assert property (@(posedge clk) disable iff (!rst_n)
        bus_oe |-> (!en_n && wr_n));

    // R12: at most one load strobe at a time.
    a_r12_onehot_load: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(ld_strobe));

    // R6: the high status half follows a low status read.
    a_r6_status_order: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_sel == T_STHI) |-> ($past(rd_sel) == T_STLO));

    // R9/R10: a device whose select differs from its page never drives reads.
    a_r9_no_read_deselected: assert property (@(posedge clk) disable iff (!rst_n)
        (dsel_q != page_q) |-> !bus_oe);
endmodule

// File: tb/cam_host_seq_test.sv
// Bench: directed corner cases then seeded random cycles, every cycle
// checked against a bench model built from the requirements.
module cam_host_seq_test;
    localparam logic [3:0] DEVID = 4'h5;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        en_n = 1'b1, cmd_n = 1'b1, wr_n = 1'b1;
    logic [15:0] bus_in = '0, nfa_in = '0, arr_rd_data = '0;
    logic [31:0] status_in = '0;
    logic [15:0] bus_out, ld_strobe;
    logic        bus_oe, arr_we, arr_re;
    logic [3:0]  rd_sel;
    logic [1:0]  arr_mode;

    int total = 0, bad = 0;
    bit finished = 0;

    // Model state
    logic [15:0] m_rf [16];
    bit          m_tp, m_af, m_sh;
    logic [2:0]  m_tc, m_ps, m_pd;
    logic [11:0] m_psi, m_pdi;

    always #4 clk = ~clk;

    cam_host_seq #(.DW(16), .DEV_ID(DEVID)) uut (
        .clk(clk), .rst_n(rst_n), .en_n(en_n), .cmd_n(cmd_n), .wr_n(wr_n),
        .bus_in(bus_in), .status_in(status_in), .nfa_in(nfa_in),
        .arr_rd_data(arr_rd_data), .bus_out(bus_out), .bus_oe(bus_oe),
        .ld_strobe(ld_strobe), .rd_sel(rd_sel), .arr_we(arr_we),
        .arr_re(arr_re), .arr_mode(arr_mode)
    );

    task automatic chk(input bit ok, input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s: actual=%h expected=%h at %0t", tag, what, act, exp, $time);
        end
    endtask

    task automatic model_reset();
        for (int k = 0; k < 16; k++) m_rf[k] = '0;
        m_tp = 0; m_af = 0; m_sh = 0;
        m_tc = '0; m_ps = '0; m_pd = '0; m_psi = '0; m_pdi = '0;
    endtask

    // One bus cycle: en/cmd/wr are active-high "do" flags here.
    task automatic step(input bit en, input bit cmd, input bit wr, input logic [15:0] d);
        int t;
        string tag;
        bit match, bc, acc, eoe, instr;
        logic [15:0] eld, eout;
        logic [2:0] c;
        @(negedge clk);
        en_n = ~en; cmd_n = ~cmd; wr_n = ~wr; bus_in = d;
        status_in = $urandom; nfa_in = 16'($urandom); arr_rd_data = 16'($urandom);
        #1;
        match = (m_rf[6] == m_rf[4]);
        bc = (m_rf[6] == 16'hFFFF);
        t = 0; tag = "R1"; c = '0;
        if (en) begin
            if (cmd) begin
                if (m_tp) begin
                    case (m_tc)
                        3'd0: t = 2; 3'd1: t = 3; 3'd2: t = 4; 3'd3: t = 5; 3'd4: t = 6;
                        3'd5: t = wr ? 0 : 7;
                        3'd6: t = wr ? 0 : 10;
                        default: t = wr ? 0 : 11;
                    endcase
                    tag = (m_tc == 3'd5) ? "R5" : (m_tc > 3'd5 ? "R8" : "R4");
                end else if (wr) begin
                    t = m_af ? 2 : 1; tag = m_af ? "R3" : "R2";
                end else begin
                    t = m_sh ? 9 : 8; tag = "R6";
                end
            end else begin
                c = wr ? m_pd : m_ps;
                t = (c == 0) ? 12 : (c == 1) ? 13 : (c == 2) ? 14 : 15;
                tag = "R7";
            end
        end
        acc = en && (wr ? (match || bc || t == 6 || (t == 1 && d[15:12] == 4'd1 && d[3:0] == 4'd4))
                        : match);
        if (en && !match)
            tag = (wr && (t == 6 || t == 1) && !bc) ? "R11" : (bc ? "R10" : "R9");
        eoe = acc && !wr;
        eld = (acc && wr && t != 0) ? (16'd1 << t) : 16'd0;
        eout = '0;
        if (eoe) begin
            case (t)
                7:  eout = nfa_in;
                8:  eout = status_in[15:0];
                9:  eout = status_in[31:16];
                10: eout = {DEVID, m_psi};
                11: eout = {4'h0, m_pdi};
                15: eout = arr_rd_data;
                default: eout = m_rf[t];
            endcase
        end
        chk(bus_oe == eoe, tag, "R1 bus_oe", 32'(bus_oe), 32'(eoe));
        chk(bus_out == eout, tag, "bus_out", 32'(bus_out), 32'(eout));
        chk(ld_strobe == eld, tag, "R12 ld_strobe", 32'(ld_strobe), 32'(eld));
        chk(arr_re == (eoe && t == 15), tag, "arr_re", 32'(arr_re), 32'(eoe && t == 15));
        if ((eoe || eld != 0) && t == 15)
            chk(arr_mode == ((c == 4) ? 2'd1 : (c == 5) ? 2'd2 : 2'd0), "R7", "arr_mode",
                32'(arr_mode), 32'((c == 4) ? 2'd1 : (c == 5) ? 2'd2 : 2'd0));
        // Model update, as the clock edge would apply it.
        if (acc) begin
            instr = wr && t == 1;
            if (wr && ((t >= 2 && t <= 6) || (t >= 12 && t <= 14))) m_rf[t] = d;
            m_tp = instr && d[15:12] == 4'd1 && !d[3];
            m_tc = d[2:0];
            m_af = instr && !(d[15:12] inside {4'd1, 4'd2, 4'd3}) && d[11];
            if (instr && d[15:12] == 4'd2 && d[2:0] <= 3'd5 && d[2:0] != 3'd4) begin
                m_ps = d[2:0]; m_psi = d[11:0];
            end
            if (instr && d[15:12] == 4'd3 && d[2:0] <= 3'd5) begin
                m_pd = d[2:0]; m_pdi = d[11:0];
            end
        end
        m_sh = acc && cmd && !wr && t == 8;
    endtask

    task automatic summary();
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    endtask

    // Watchdog: a hung run counts as a failed check.
    initial begin
        #(8 * 200000);
        if (!finished) begin
            total++; bad++;
            $display("FAIL watchdog expired");
            summary();
        end
    end

    initial begin
        void'($urandom(32'd2024));
        model_reset();
        repeat (3) @(posedge clk);
        @(negedge clk); rst_n = 1'b1;
        #1;
        // R13: reset state, nothing loaded or driven while idle
        chk(bus_oe == 1'b0, "R13", "reset bus_oe", 32'(bus_oe), 0);
        chk(ld_strobe == 16'd0, "R13", "reset ld_strobe", 32'(ld_strobe), 0);
        step(1, 0, 1, 16'h0000);           // R7/R13: data write to comparand
        step(1, 0, 0, 16'h0000);           // R7: data read comparand
        step(1, 1, 0, 16'h0000);           // R8 path default readback via xfer next
        step(1, 1, 1, 16'h1006); step(1, 1, 0, 16'h0); // R8: source readback
        // R2/R6: default command write, status alternation, idle restarts
        step(1, 1, 1, 16'h0042);
        step(1, 1, 0, 0); step(1, 1, 0, 0); step(1, 1, 0, 0);
        step(1, 1, 0, 0); step(0, 0, 0, 0); step(1, 1, 0, 0);
        // R3: address flag
        step(1, 1, 1, 16'h0800); step(0, 0, 0, 0); step(1, 1, 1, 16'h1234);
        step(1, 1, 1, 16'h0000);
        // R4: transfer to control, write then read, data cancel
        step(1, 1, 1, 16'h1001); step(1, 1, 1, 16'hBEEF);
        step(1, 1, 1, 16'h1001); step(0, 1, 1, 0); step(1, 1, 0, 0);
        step(1, 1, 1, 16'h1001); step(1, 0, 1, 16'h5555); step(1, 1, 1, 16'h0001);
        step(1, 1, 1, 16'h1000); step(1, 1, 0, 0);
        // R5: next-free cannot be written, can be read
        step(1, 1, 1, 16'h1005); step(1, 1, 1, 16'hAAAA);
        step(1, 1, 1, 16'h1005); step(1, 1, 0, 0);
        // R7/R8: persistent selections and readback
        step(1, 1, 1, 16'h2A31); step(1, 1, 1, 16'h3B02);
        step(1, 0, 1, 16'h7777); step(1, 0, 0, 0);
        step(1, 1, 1, 16'h2004); step(1, 1, 1, 16'h1006); step(1, 1, 0, 0);
        step(1, 1, 1, 16'h1007); step(1, 1, 0, 0);
        step(1, 1, 1, 16'h3004); step(1, 0, 1, 16'h0101);
        step(1, 1, 1, 16'h2005); step(1, 0, 0, 0);
        step(1, 1, 1, 16'h3000); step(1, 1, 1, 16'h2000);
        // R9/R11: move page away, then recover through device select
        step(1, 1, 1, 16'h1002); step(1, 1, 1, 16'h0003);
        step(1, 1, 0, 0); step(1, 0, 1, 16'h1111); step(1, 1, 1, 16'h0800);
        step(1, 1, 1, 16'h1004); step(1, 1, 1, 16'hFFFF);
        // R10: broadcast accepts writes, drives no reads
        step(1, 0, 1, 16'h2222); step(1, 1, 0, 0); step(1, 0, 0, 0);
        step(1, 1, 1, 16'h1004); step(1, 1, 1, 16'h0003);
        step(1, 1, 0, 0); step(1, 0, 0, 0);
        // Random phase
        for (int i = 0; i < 3000; i++) begin
            logic [15:0] d;
            int r;
            r = $urandom % 8;
            case (r)
                0: d = {4'h1, 9'h0, 3'($urandom)};
                1: d = {4'h2, 12'($urandom)};
                2: d = {4'h3, 12'($urandom)};
                3: d = {4'h0, 12'($urandom)};
                4: d = 16'h0000;
                default: d = 16'($urandom);
            endcase
            step(($urandom % 6) != 0, $urandom % 2, $urandom % 2, d);
        end
        finished = 1;
        summary();
    end
endmodule